// File: doc/BRIEF.md
# PCI Target Exclusive-Access Lock Tracker

This block sits beside a PCI target state machine and follows the bus control lines to decide whether the target is held for exclusive use by one master. On every rising PCI clock edge it samples the active-low FRAME#, LOCK#, IRDY# and TRDY# lines and a decoded address-hit input. From these it keeps a lock flag, and it tells the target state machine when an access has to be refused with a retry.

The owner of a lock is never identified by any master number. The only thing that marks a master as the owner is the LOCK# level in the address clock. If LOCK# is high there, the access comes from the owner, or it is a fresh attempt to take the lock. If LOCK# is low there, another master is holding LOCK# for its own purposes. Entering the lock needs three things in this order: a hit with LOCK# high, then LOCK# low in the next clock, then a completed data transfer. Leaving the lock is allowed only in the clock after the final data transfer of a transaction to this target. Address decode, DEVSEL# timing, parity and driving STOP# are left to the surrounding target logic.

Top module: `pci_lock_tracker`

## Requirements
- R1: After the asynchronous active-low reset is applied, `locked` and `retry_req` are both 0 at once, without waiting for a clock edge.
- R2: An address clock is a clock with FRAME# low that follows a clock with FRAME# high. The target becomes locked when three things happen in order: in the address clock, `addr_hit` is 1 and LOCK# is high while unlocked; in the next clock, LOCK# is low; later in that same transaction, a clock has both IRDY# and TRDY# low. `locked` goes to 1 after the edge of that data-transfer clock.
- R3: If LOCK# is still high in the clock after the address clock, the transaction does not lock the target, even when data is transferred.
- R4: If a lock-entry transaction ends before any data transfer, the target stays unlocked. This covers the case where FRAME# and IRDY# both go high, as after a retry or an abort. A later transaction does not inherit the unfinished entry.
- R5: A transaction whose address clock has `addr_hit` at 0 never changes `locked`. It can neither lock the target nor release it.
- R6: While unlocked, an access to this target with LOCK# already low in the address clock is served normally. `retry_req` stays 0 and `locked` stays 0.
- R7: While locked, an access to this target with LOCK# low in the address clock raises `retry_req` for exactly one clock, the clock right after the address clock. `locked` does not change.
- R8: While locked, an access to this target with LOCK# high in the address clock is treated as the owner's access. `retry_req` stays 0.
- R9: The last data transfer is a clock with IRDY# and TRDY# low and FRAME# high. If this target is locked and LOCK# is high in the clock after the last data transfer of a transaction to it, `locked` goes to 0 after that clock's edge.
- R10: If LOCK# is low in the clock after that last data transfer, the target stays locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Bus FRAME#, active low |
| lock_n | input | 1 | Bus LOCK#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| trdy_n | input | 1 | Bus TRDY#, active low |
| addr_hit | input | 1 | 1 when the address clock decodes to this target |
| locked | output | 1 | 1 while the target is held for exclusive access |
| retry_req | output | 1 | One-clock request to end the current access with a retry |

## Verification
The main function is driven with several kinds of transactions to this target: a normal lock entry, an entry where LOCK# never goes low, an entry that is cut off before any data moves, an access that arrives with LOCK# already low while the target is unlocked, a foreign access while locked, and an owner access that lets LOCK# go. Side by side, these show that the LOCK# level in the address clock and in the clock after it are the two samples that decide between owner, stranger and entry. Transactions to other targets are added in both the entry phase and the release phase, to show that `addr_hit` gates every change of state. Asynchronous reset is applied in the middle of a lock.

// File: rtl/pci_lock_tracker.sv
module pci_lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic lock_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic addr_hit,
  output logic locked,
  output logic retry_req
);

  logic frame_q;   // FRAME# one clock earlier
  logic in_txn;    // current transaction targets this device
  logic cand;      // address clock looked like a lock entry
  logic pend;      // entry confirmed by LOCK#, waiting for data
  logic done_q;    // last data transfer happened in the previous clock

  wire addr_clk = !frame_n && frame_q;
  wire idle     = frame_n && irdy_n;
  wire xfer     = !irdy_n && !trdy_n && in_txn;
  wire arm      = cand && !lock_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= 1'b1;
      in_txn    <= 1'b0;
      cand      <= 1'b0;
      pend      <= 1'b0;
      done_q    <= 1'b0;
      retry_req <= 1'b0;
    end else begin
      frame_q   <= frame_n;
      cand      <= addr_clk && addr_hit && !locked && lock_n;
      retry_req <= addr_clk && addr_hit && locked && !lock_n;
      done_q    <= xfer && frame_n;
      if (addr_clk)  in_txn <= addr_hit;
      else if (idle) in_txn <= 1'b0;
      if (addr_clk || idle) pend <= 1'b0;
      else if (arm)         pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            locked <= 1'b0;
    else if ((pend || arm) && xfer)        locked <= 1'b1;
    else if (locked && done_q && lock_n)   locked <= 1'b0;
  end

  assert_retry_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);

  assert_retry_keeps_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> locked);

  assert_no_retry_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_clk && !locked) |=> !retry_req);

  assert_owner_not_retried_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_clk && lock_n) |=> !retry_req);

  assert_entry_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(!irdy_n && !trdy_n));

  assert_release_needs_lock_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(lock_n));

endmodule

// File: tb/sim_pci_lock_tracker.sv
`timescale 1ns/1ps
module sim_pci_lock_tracker;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, lock_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, addr_hit = 1'b0;
  logic locked, retry_req;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pci_lock_tracker u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lock_n(lock_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .addr_hit(addr_hit),
    .locked(locked), .retry_req(retry_req)
  );

  // {frame_n, lock_n, irdy_n, trdy_n, addr_hit, exp_locked, exp_retry}
  localparam int N = 28;
  localparam logic [6:0] VEC [N] = '{
    7'b11110_00,                // idle
    7'b01111_00,                // R2 entry address, LOCK# high
    7'b10010_00,                // R2 LOCK# low
    7'b10000_10,                // R2 data -> locked
    7'b10110_10,                // R10 LOCK# held low after last data
    7'b00111_11,                // R7 stranger address -> retry pulse
    7'b10110_10,                // R7 pulse ends, lock kept
    7'b10110_10,
    7'b01111_10,                // R8 owner address
    7'b00010_10,
    7'b10000_10,                // R9 last data
    7'b11110_00,                // R9 LOCK# high -> released
    7'b00111_00,                // R6 LOCK# low while unlocked
    7'b10000_00,                // R6 served, no lock
    7'b11110_00,
    7'b01111_00,                // R3 entry, LOCK# stays high
    7'b11000_00,                // R3 data, no lock
    7'b11110_00,
    7'b01111_00,                // R4 entry
    7'b10010_00,                // R4 LOCK# low
    7'b10110_00,                // R4 ended without data
    7'b01111_00,                // R4 new transaction, LOCK# high
    7'b11000_00,                // R4 data must not lock
    7'b11110_00,
    7'b01110_00,                // R5 entry pattern to other target
    7'b10010_00,
    7'b10000_00,                // R5 no lock
    7'b10110_00
  };
  localparam int REQ [N] = '{1,2,2,2,10,7,7,7,8,8,9,9,6,6,6,3,3,3,4,4,4,4,4,4,5,5,5,5};

  task automatic check(input string req, input logic act_l, input logic exp_l,
                       input logic act_r, input logic exp_r);
    checks++;
    if (act_l !== exp_l || act_r !== exp_r) begin
      failures++;
      $display("FAIL %s locked=%b exp %b retry_req=%b exp %b", req, act_l, exp_l, act_r, exp_r);
    end
  endtask

  task automatic cyc(input logic [4:0] v);
    {frame_n, lock_n, irdy_n, trdy_n, addr_hit} = v;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check("R1", locked, 1'b0, retry_req, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", locked, 1'b0, retry_req, 1'b0);

    for (int k = 0; k < N; k++) begin
      cyc(VEC[k][6:2]);
      check($sformatf("R%0d", REQ[k]), locked, VEC[k][1], retry_req, VEC[k][0]);
    end

    // R2: lock again with a multi-phase entry
    cyc(5'b01111);
    cyc(5'b00010);
    cyc(5'b00000);
    check("R2", locked, 1'b1, retry_req, 1'b0);
    cyc(5'b10000);
    cyc(5'b10110);
    check("R10", locked, 1'b1, retry_req, 1'b0);
    // R5: other target completes with LOCK# high afterwards, lock kept
    cyc(5'b01110);
    cyc(5'b11000);
    cyc(5'b11110);
    check("R5", locked, 1'b1, retry_req, 1'b0);
    cyc(5'b11110);
    check("R5", locked, 1'b1, retry_req, 1'b0);
    // R1: asynchronous reset in mid-lock
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", locked, 1'b0, retry_req, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(5'b11110);
    check("R1", locked, 1'b0, retry_req, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule